// File: doc/BRIEF.md
# Password-Gated Configuration Register Bank

This block holds a set of byte-wide configuration registers on a small 8-bit host I/O bus. The bus has a 12-bit address, a read strobe, a write strobe, write data and read data. The registers have fixed addresses from 0xF8D to 0xF98. Register k sits at address 0xF8C + k. In the normal state they are hidden and return bus-float (0xFF). To reach a register, the host writes a one-time key byte to the key address 0xF8F. The single bus access that follows and lands in the register range is served. The bank then locks itself again. A write to 0xF8F while the bank is open is a plain write to register 3.

The `variant_i` input selects one of three chip variants:
- **Original variant:** uses key 0xE2 and implements registers 1 to 7.
- **Later variant:** uses key 0xE3 and implements registers 1 to 7.
- **Indexed variant:** ignores gating at the fixed addresses. The host writes the two-byte sequence 0xE4, 0x80 to the key address. After that the registers are reached through an index port and a data port, and no key is needed. In this mode registers 1 to 12 exist.

All register contents drive a flat parallel configuration output that the surrounding chip decodes. Reads are combinational in the strobe cycle. Writes take effect at the clock edge that ends the strobe cycle.

Top module: `cfg_gate_bank`

## Requirements
- R1: After reset (`rst_ni` low), the bank is locked, indexed mode is off, and every register (and so all of `cfg_o`) is 0x00, so the low-power bit of register 1 is clear.
- R2: While locked, a read of any address in 0xF8D..0xF98 returns 0xFF, and a write there changes no register except through the key mechanism of R3.
- R3: With `variant_i` = 0 (or the reserved value 3), writing 0xE2 to 0xF8F opens the bank. With `variant_i` = 1, the key is 0xE3. Any other byte, including the other variant's key, leaves the bank locked.
- R4: Once open, the first read or write strobe to 0xF8D..0xF98 is served and the bank locks again. A write to 0xF8F in that access stores into register 3 and does not reopen the bank.
- R5: Every register bit is readable and writable. Register k appears on `cfg_o[8*k-1 : 8*(k-1)]`.
- R6: Strobes to addresses outside 0xF8D..0xF98 and outside the active index/data pair read 0xFF, write nothing, and leave an open bank open.
- R7: With `variant_i` 0 or 1, addresses 0xF94..0xF98 (registers 8 to 12) read 0x00 while the bank is open, and writes to them are ignored.
- R8: With `variant_i` = 2, the fixed addresses always read 0xFF and ignore writes. Writing 0xE4 and then 0x80 to 0xF8F enables indexed mode, which stays on until reset. Any other strobe to 0xF8D..0xF98 between these two writes cancels the sequence.
- R9: In indexed mode, a write to the index port 0xE0E stores an index byte, which reads back from 0xE0E. Reads and writes of the data port 0xE0F reach register number index (legacy address minus 0xF8C). Indices 0 and above 12 read 0x00 and ignore writes, and the fixed range, including 0xF8F, reads 0xFF.
- R10: `rdata_o` is 0xFF in every cycle in which `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| variant_i | input | 2 | Chip variant: 0 original, 1 later, 2 indexed, 3 as 0 |
| addr_i | input | 12 | I/O address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational; 0xFF when not decoded |
| cfg_o | output | 96 | All registers, register k in byte k-1 |

## Verification
The assertions assume three things about the inputs:
- `variant_i` changes only while reset is held.
- `rd_i` and `wr_i` are never high in the same cycle.
- Each strobe lasts one clock.

The stimulus follows these rules. It sets the variant inside a reset task, and every bus task raises exactly one strobe for one cycle, followed by an idle cycle. Under those conditions the one-shot lock, the key cause of each unlock and the permanence of indexed mode can be checked clock by clock without modelling the bus further.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  parameter int unsigned ADDR_W_DEF = 12;
  parameter int unsigned DATA_W_DEF = 8;
  parameter int unsigned NREG_DEF = 12;
  parameter int unsigned NREG_BASE_DEF = 7;

  parameter logic [ADDR_W_DEF-1:0] LEG_BASE_DEF = 12'hF8C;
  parameter logic [ADDR_W_DEF-1:0] KEY_ADDR_DEF = 12'hF8F;
  parameter logic [ADDR_W_DEF-1:0] IDX_ADDR_DEF = 12'hE0E;
  parameter logic [ADDR_W_DEF-1:0] DAT_ADDR_DEF = 12'hE0F;

  parameter logic [7:0] KEY_ORIG = 8'hE2;
  parameter logic [7:0] KEY_LATER = 8'hE3;
  parameter logic [7:0] RELOC_KEY1 = 8'hE4;
  parameter logic [7:0] RELOC_KEY2 = 8'h80;

  typedef enum logic [1:0] {
    VAR_ORIG    = 2'd0,
    VAR_LATER   = 2'd1,
    VAR_INDEXED = 2'd2,
    VAR_RSVD    = 2'd3
  } variant_e;

  typedef struct packed {
    logic       leg;   // inside fixed register range
    logic       key;   // key address
    logic       idx;   // index port
    logic       dat;   // data port
    logic [7:0] sel;   // register number from legacy address
  } dec_t;
endpackage

// File: rtl/cfg_gate_decode.sv
module cfg_gate_decode
  import cfg_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned NREG = NREG_DEF,
  parameter logic [ADDR_W-1:0] LEG_BASE = LEG_BASE_DEF,
  parameter logic [ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF,
  parameter logic [ADDR_W-1:0] IDX_ADDR = IDX_ADDR_DEF,
  parameter logic [ADDR_W-1:0] DAT_ADDR = DAT_ADDR_DEF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam logic [ADDR_W-1:0] LEG_LAST = LEG_BASE + ADDR_W'(NREG);

  always_comb begin
    dec_o.leg = (addr_i > LEG_BASE) && (addr_i <= LEG_LAST);
    dec_o.key = (addr_i == KEY_ADDR);
    dec_o.idx = (addr_i == IDX_ADDR);
    dec_o.dat = (addr_i == DAT_ADDR);
    dec_o.sel = 8'(addr_i - LEG_BASE);
  end
endmodule

// File: rtl/cfg_gate_lock.sv
module cfg_gate_lock
  import cfg_gate_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              indexed_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              leg_i,
  input  logic              key_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o,
  output logic              idx_mode_o
);
  logic open_q, arm_q, idx_q;
  logic leg_strobe, key_wr;

  assign leg_strobe = (rd_i || wr_i) && leg_i;
  assign key_wr     = wr_i && key_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      arm_q  <= 1'b0;
      idx_q  <= 1'b0;
    end else if (indexed_i) begin
      open_q <= 1'b0;
      if (leg_strobe) begin
        if (arm_q && key_wr && wdata_i == DATA_W'(RELOC_KEY2)) idx_q <= 1'b1;
        // any other range strobe drops a half-entered sequence
        arm_q <= !idx_q && key_wr && wdata_i == DATA_W'(RELOC_KEY1);
      end
    end else begin
      arm_q <= 1'b0;
      // open: any range strobe closes; locked: only the key opens
      if (leg_strobe) open_q <= !open_q && key_wr && wdata_i == key_i;
    end
  end

  assign open_o     = open_q;
  assign idx_mode_o = idx_q;
endmodule

// File: rtl/cfg_gate_regs.sv
module cfg_gate_regs #(
  parameter int unsigned NREG = 12,
  parameter int unsigned DATA_W = 8,
  parameter logic [NREG*DATA_W-1:0] RST_VAL = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [DATA_W-1:0]      sel_i,
  input  logic [DATA_W-1:0]      nimpl_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NREG*DATA_W-1:0] cfg_o
);
  logic [DATA_W-1:0] rd_term [NREG];

  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic hit;
    assign hit = (sel_i == DATA_W'(k)) && (DATA_W'(k) <= nimpl_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= RST_VAL[(k-1)*DATA_W +: DATA_W];
      else if (we_i && hit)   q <= wdata_i;
    end

    assign cfg_o[(k-1)*DATA_W +: DATA_W] = q;
    assign rd_term[k-1] = hit ? q : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) rdata_o = rdata_o | rd_term[i];
  end
endmodule

// File: rtl/cfg_gate_bank.sv
module cfg_gate_bank
  import cfg_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned NREG = NREG_DEF,
  parameter int unsigned NREG_BASE = NREG_BASE_DEF,
  parameter logic [ADDR_W-1:0] LEG_BASE = LEG_BASE_DEF,
  parameter logic [ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF,
  parameter logic [ADDR_W-1:0] IDX_ADDR = IDX_ADDR_DEF,
  parameter logic [ADDR_W-1:0] DAT_ADDR = DAT_ADDR_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             variant_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NREG*DATA_W-1:0] cfg_o
);
  localparam logic [DATA_W-1:0] FLOAT = '1;

  dec_t dec;
  logic indexed, open_w, idx_mode_w;
  logic [DATA_W-1:0] key, nimpl, index_q, sel, reg_rdata;
  logic leg_hit, dat_hit, idx_hit, reg_we;

  assign indexed = (variant_i == VAR_INDEXED);
  assign key     = (variant_i == VAR_LATER) ? DATA_W'(KEY_LATER) : DATA_W'(KEY_ORIG);
  assign nimpl   = indexed ? DATA_W'(NREG) : DATA_W'(NREG_BASE);

  cfg_gate_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .LEG_BASE(LEG_BASE),
    .KEY_ADDR(KEY_ADDR), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_dec (
    .addr_i(addr_i),
    .dec_o (dec)
  );

  cfg_gate_lock #(.DATA_W(DATA_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .indexed_i (indexed),
    .key_i     (key),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .leg_i     (dec.leg),
    .key_addr_i(dec.key),
    .wdata_i   (wdata_i),
    .open_o    (open_w),
    .idx_mode_o(idx_mode_w)
  );

  assign leg_hit = dec.leg && open_w && !indexed;
  assign dat_hit = idx_mode_w && dec.dat;
  assign idx_hit = idx_mode_w && dec.idx;
  assign sel     = dat_hit ? index_q : DATA_W'(dec.sel);
  assign reg_we  = wr_i && (leg_hit || dat_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              index_q <= '0;
    else if (wr_i && idx_hit) index_q <= wdata_i;
  end

  cfg_gate_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .sel_i  (sel),
    .nimpl_i(nimpl),
    .wdata_i(wdata_i),
    .rdata_o(reg_rdata),
    .cfg_o  (cfg_o)
  );

  always_comb begin
    rdata_o = FLOAT;
    if (rd_i) begin
      if (leg_hit || dat_hit) rdata_o = reg_rdata;
      else if (idx_hit)       rdata_o = index_q;
    end
  end
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG = 12,
  parameter logic [ADDR_W-1:0] LEG_BASE = 12'hF8C,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'hF8F
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             variant_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   rd_i,
  input logic                   wr_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic [DATA_W-1:0]      rdata_o,
  input logic [NREG*DATA_W-1:0] cfg_o,
  input logic                   open_w,
  input logic                   idx_mode_w
);
  logic in_range;
  assign in_range = (addr_i > LEG_BASE) && (addr_i <= LEG_BASE + ADDR_W'(NREG));

  // R2
  locked_read_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !open_w && in_range) |-> rdata_o == '1);

  // R2
  locked_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !open_w && in_range) |=> $stable(cfg_o));

  // R3
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_w) |-> $past(wr_i && addr_i == KEY_ADDR &&
                            (wdata_i == 8'hE2 || wdata_i == 8'hE3)));

  // R4
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_w && (rd_i || wr_i) && in_range) |=> !open_w);

  // R8
  idx_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_mode_w |=> idx_mode_w);

  // R8
  idx_variant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_mode_w |-> variant_i == 2'd2);

  // R10
  idle_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '1);

  // R3 input rule: variant fixed outside reset
  variant_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(variant_i));

  // R4 input rule: one strobe kind per cycle
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
endmodule

bind cfg_gate_bank cfg_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
  .LEG_BASE(LEG_BASE), .KEY_ADDR(KEY_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .variant_i (variant_i),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .cfg_o     (cfg_o),
  .open_w    (open_w),
  .idx_mode_w(idx_mode_w)
);

// File: tb/cfg_gate_bank_test.sv
module cfg_gate_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [95:0] cfg;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cfg_gate_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .cfg_o(cfg)
  );

  function automatic logic [7:0] slot(int k);
    return cfg[(k-1)*8 +: 8];
  endfunction

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(logic [1:0] v);
    rst_n = 1'b0;
    variant = v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic bus_write(logic [11:0] a, logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  // driver: pushes expected read data, monitor compares
  task automatic bus_read(logic [11:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd) begin
      logic [7:0] e;
      string t;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read %02h expected none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // ---- original variant ----
    apply_reset(2'd0);
    check("R1 reset cfg", cfg, '0);
    @(negedge clk);
    check("R10 idle rdata", {88'd0, rdata}, {88'd0, 8'hFF});
    bus_read(12'hF8D, 8'hFF, "R2 locked read");
    bus_read(12'hF98, 8'hFF, "R2 locked read top");
    bus_write(12'hF8D, 8'h55);
    check("R2 locked write ignored", {88'd0, slot(1)}, 96'h0);
    bus_write(12'hF8F, 8'hE3);
    bus_read(12'hF8D, 8'hFF, "R3 wrong key");
    bus_write(12'hF8F, 8'hE2);
    bus_read(12'hF8D, 8'h00, "R3 key opens");
    bus_read(12'hF8D, 8'hFF, "R4 relocked after read");

    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8D, 8'h80);
    check("R5 bit7 set cfg", {88'd0, slot(1)}, {88'd0, 8'h80});
    bus_write(12'hF8F, 8'hE2); bus_read(12'hF8D, 8'h80, "R5 bit7 readback");
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8D, 8'h00);
    check("R5 restore", {88'd0, slot(1)}, 96'h0);
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8D, 8'hA5);
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8E, 8'h3C);
    check("R5 reg2 slot", {88'd0, slot(2)}, {88'd0, 8'h3C});
    check("R5 reg1 slot", {88'd0, slot(1)}, {88'd0, 8'hA5});

    // R6: undecoded accesses keep the bank open
    bus_write(12'hF8F, 8'hE2);
    bus_read(12'h300, 8'hFF, "R6 outside read");
    bus_write(12'h301, 8'h77);
    bus_read(12'hE0F, 8'hFF, "R6 data port inactive");
    bus_read(12'hF8D, 8'hA5, "R6 unlock survives");

    // R7
    bus_write(12'hF8F, 8'hE2); bus_read(12'hF94, 8'h00, "R7 unimpl reads zero");
    bus_read(12'hF94, 8'hFF, "R7 locked after unimpl read");
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF98, 8'h11);
    check("R7 unimpl write ignored", {88'd0, slot(12)}, 96'h0);

    // R4: key address as register 3, second write dropped
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8F, 8'h12);
    check("R4 reg3 via key addr", {88'd0, slot(3)}, {88'd0, 8'h12});
    bus_read(12'hF8D, 8'hFF, "R4 no reopen");
    bus_write(12'hF8F, 8'hE2); bus_write(12'hF8D, 8'h01); bus_write(12'hF8D, 8'h02);
    check("R4 second write dropped", {88'd0, slot(1)}, {88'd0, 8'h01});

    // ---- later variant ----
    apply_reset(2'd1);
    check("R1 reset cfg later", cfg, '0);
    bus_write(12'hF8F, 8'hE2);
    bus_read(12'hF8D, 8'hFF, "R3 old key rejected");
    bus_write(12'hF8F, 8'hE3);
    bus_read(12'hF8D, 8'h00, "R3 later key opens");
    bus_write(12'hF8F, 8'hE3); bus_write(12'hF93, 8'hC3);
    check("R5 reg7 slot", {88'd0, slot(7)}, {88'd0, 8'hC3});
    bus_write(12'hF8F, 8'hE3); bus_read(12'hF93, 8'hC3, "R5 reg7 readback");

    // ---- indexed variant ----
    apply_reset(2'd2);
    bus_write(12'hF8F, 8'hE2);
    bus_read(12'hF8D, 8'hFF, "R8 no key gating");
    bus_write(12'hF8F, 8'hE4); bus_write(12'hF8D, 8'h80); bus_write(12'hF8F, 8'h80);
    bus_read(12'hE0F, 8'hFF, "R8 broken sequence");
    bus_write(12'hF8F, 8'hE4); bus_write(12'hF8F, 8'h80);
    bus_read(12'hF8F, 8'hFF, "R9 key addr floats");
    bus_write(12'hE0E, 8'h07);
    bus_read(12'hE0E, 8'h07, "R9 index readback");
    bus_write(12'hE0F, 8'h00);
    bus_read(12'hE0F, 8'h00, "R9 reg7 zero");
    bus_write(12'hE0F, 8'hCB);
    bus_read(12'hE0F, 8'hCB, "R9 reg7 CB");
    check("R9 reg7 slot", {88'd0, slot(7)}, {88'd0, 8'hCB});
    bus_write(12'hE0E, 8'h01); bus_write(12'hE0F, 8'h5A);
    bus_read(12'hE0F, 8'h5A, "R9 reg1 repeated access");
    bus_write(12'hE0E, 8'h0C); bus_write(12'hE0F, 8'h99);
    check("R9 reg12 slot", {88'd0, slot(12)}, {88'd0, 8'h99});
    bus_write(12'hE0E, 8'h0D); bus_write(12'hE0F, 8'h44);
    bus_read(12'hE0F, 8'h00, "R9 index 13 zero");
    bus_write(12'hE0E, 8'h00);
    bus_read(12'hE0F, 8'h00, "R9 index 0 zero");
    bus_write(12'hF8D, 8'h11);
    bus_write(12'hE0E, 8'h01);
    bus_read(12'hE0F, 8'h5A, "R9 legacy write ignored");
    bus_read(12'hF8D, 8'hFF, "R9 legacy read floats");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule